// File: doc/BRIEF.md
# Multi-Cycle Program Counter Sequencer

This block pairs an 8-bit program counter with a step counter that numbers the clock cycles spent inside one instruction. The step counter starts at zero for every instruction and climbs by one per clock. The program counter holds its value until the step counter reaches the final step of the instruction. On that step the program counter moves on, and the step counter goes back to zero.

The instruction length comes from one of two sources, chosen when the block is built. In the fixed variant every instruction lasts `FIXED_LEN` cycles. In the variable variant, used when `FIXED_LEN` is 0, the `len_sel` input gives the cycle count for the current instruction, so different instruction types can take different numbers of cycles. A jump request loads a new program-counter value. The request only counts on the last step of an instruction, where the loaded value takes the place of the increment.

Upstream decode logic drives `len_sel`, `jump_en` and `jump_tgt`. Downstream logic reads `pc` and `step` to sequence its own work.

Top module: `pc_step_sequencer`

## Requirements
- R1: A synchronous active-high `rst` sets both `pc` and `step` to 0 on the next rising clock edge. This holds even in the middle of an instruction.
- R2: With `FIXED_LEN` set to N (nonzero), every instruction lasts N cycles and `step` runs 0 to N-1. With N = 5 the steps are 0, 1, 2, 3, 4 and `pc` rises by one every five clocks.
- R3: While `step` is not on the last step of the instruction, `pc` keeps its value.
- R4: `step` rises by exactly one per clock until it reaches the last step. On the clock after the last step it returns to 0.
- R5: When the last step completes and `jump_en` is low, `pc` becomes `pc`+1.
- R6: With `FIXED_LEN` = 0, a `len_sel` value from 2 to 15 gives an instruction of exactly that many cycles, with the last step numbered `len_sel`-1.
- R7: With `FIXED_LEN` = 0, a `len_sel` of 0 or 1 gives one-cycle instructions. `step` stays 0 and `pc` advances on every clock.
- R8: When `jump_en` is high on the last step, `pc` takes `jump_tgt` on the next edge instead of the increment, and `step` returns to 0.
- R9: When `jump_en` is high on a step that is not the last, it has no effect. `pc` is unchanged and `step` still advances.
- R10: `pc` wraps from 0xFF to 0x00 on an increment.
- R11: If `len_sel` falls to a value at or below the current step plus one, the current step is treated as the last step. The instruction then ends at once instead of running past its new length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| len_sel | input | 4 | Cycle count of the current instruction (variable variant only) |
| jump_en | input | 1 | Requests a load of `jump_tgt` into `pc` on the last step |
| jump_tgt | input | 8 | Value loaded into `pc` by a jump |
| pc | output | 8 | Program counter |
| step | output | 4 | Step number within the current instruction |

## Verification
The checks on step climbing and program-counter holding assume that `len_sel` never drops below the current step while a bound on the step value is checked. The bench keeps `len_sel` steady within each instruction, except in the one scenario that lowers it on purpose to exercise R11. The assertions on advance and jump look only at clocks whose previous cycle was outside reset. For this reason the bench always applies a reset of at least one full cycle before each scenario. Jump requests are driven and released between clock edges, so every request is seen as belonging to exactly one step.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

    localparam int PC_W   = 8;
    localparam int STEP_W = 4;

    typedef logic [PC_W-1:0]   pc_t;
    typedef logic [STEP_W-1:0] step_t;

    // Control bundle for the program-counter register
    typedef struct packed {
        logic advance;   // last step reached this cycle
        logic load;      // jump requested
        pc_t  target;    // jump destination
    } pc_ctl_t;

    // Index of the final step for a requested cycle count; 0 and 1 mean one cycle
    function automatic step_t final_index(step_t cycles);
        if (cycles <= step_t'(1))
            return '0;
        return cycles - step_t'(1);
    endfunction

endpackage

// File: rtl/pcseq_term.sv
module pcseq_term
    import pcseq_pkg::*;
#(
    parameter int FIXED_LEN = 0
) (
    input  step_t len_sel,
    input  step_t step,
    output logic  is_last
);

    generate
        if (FIXED_LEN != 0) begin : g_fixed
            localparam step_t FINAL_STEP = step_t'(FIXED_LEN - 1);
            assign is_last = (step >= FINAL_STEP);
        end else begin : g_variable
            step_t final_step;
            assign final_step = final_index(len_sel);
            // ">=" closes the instruction if the length shrinks under the step
            assign is_last = (step >= final_step);
        end
    endgenerate

endmodule

// File: rtl/pcseq_step.sv
module pcseq_step
    import pcseq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  is_last,
    output step_t step
);

    always_ff @(posedge clk) begin
        if (rst)
            step <= '0;
        else if (is_last)
            step <= '0;
        else
            step <= step + step_t'(1);
    end

endmodule

// File: rtl/pcseq_pc.sv
module pcseq_pc
    import pcseq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  pc_ctl_t ctl,
    output pc_t     pc
);

    pc_t pc_next;

    always_comb begin
        pc_next = pc;
        if (ctl.advance) begin
            if (ctl.load)
                pc_next = ctl.target;
            else
                pc_next = pc + pc_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            pc <= '0;
        else
            pc <= pc_next;
    end

endmodule

// File: rtl/pc_step_sequencer.sv
module pc_step_sequencer
    import pcseq_pkg::*;
#(
    parameter int FIXED_LEN = 0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [STEP_W-1:0]   len_sel,
    input  logic                jump_en,
    input  logic [PC_W-1:0]     jump_tgt,
    output logic [PC_W-1:0]     pc,
    output logic [STEP_W-1:0]   step
);

    logic    last_step;
    step_t   step_q;
    pc_t     pc_q;
    pc_ctl_t pc_ctl;

    pcseq_term #(.FIXED_LEN(FIXED_LEN)) u_term (
        .len_sel (len_sel),
        .step    (step_q),
        .is_last (last_step)
    );

    pcseq_step u_step (
        .clk     (clk),
        .rst     (rst),
        .is_last (last_step),
        .step    (step_q)
    );

    always_comb begin
        pc_ctl.advance = last_step;
        pc_ctl.load    = jump_en;
        pc_ctl.target  = jump_tgt;
    end

    pcseq_pc u_pc (
        .clk (clk),
        .rst (rst),
        .ctl (pc_ctl),
        .pc  (pc_q)
    );

    assign pc   = pc_q;
    assign step = step_q;

endmodule

// File: rtl/pcseq_checker.sv
module pcseq_checker
    import pcseq_pkg::*;
#(
    parameter int FIXED_LEN = 0
) (
    input logic  clk,
    input logic  rst,
    input step_t len_sel,
    input logic  jump_en,
    input pc_t   jump_tgt,
    input pc_t   pc,
    input step_t step
);

    localparam step_t STEP_BOUND = (FIXED_LEN != 0) ? step_t'(FIXED_LEN - 1)
                                                    : step_t'((1 << STEP_W) - 2);

    // High when the previous cycle was outside reset
    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (pc == '0 && step == '0));

    a_r3_pc_holds: assert property (@(posedge clk) disable iff (rst || !armed)
        (step != '0) |-> $stable(pc));

    a_r4_step_climbs: assert property (@(posedge clk) disable iff (rst || !armed)
        (step != '0) |-> (step == step_t'($past(step) + step_t'(1))));

    a_r2_step_bound: assert property (@(posedge clk) disable iff (rst)
        step <= STEP_BOUND);

    a_r5_advance: assert property (@(posedge clk) disable iff (rst || !armed)
        (step == '0 && !$past(jump_en)) |-> (pc == pc_t'($past(pc) + pc_t'(1))));

    a_r8_jump_load: assert property (@(posedge clk) disable iff (rst || !armed)
        (step == '0 && $past(jump_en)) |-> (pc == $past(jump_tgt)));

    generate
        if (FIXED_LEN == 0) begin : g_var_checks
            a_r7_single_cycle: assert property (@(posedge clk) disable iff (rst || !armed)
                ($past(len_sel) <= step_t'(1)) |-> (step == '0));
        end
    endgenerate

endmodule

bind pc_step_sequencer pcseq_checker #(.FIXED_LEN(FIXED_LEN)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .len_sel  (len_sel),
    .jump_en  (jump_en),
    .jump_tgt (jump_tgt),
    .pc       (pc),
    .step     (step)
);

// File: tb/pc_step_sequencer_test.sv
`timescale 1ns/1ps
module pc_step_sequencer_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] len_sel = 4'd0;
    logic       jump_en = 1'b0;
    logic [7:0] jump_tgt = 8'd0;
    logic [7:0] pc, pc_f;
    logic [3:0] step, step_f;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pc_step_sequencer uut (
        .clk(clk), .rst(rst), .len_sel(len_sel), .jump_en(jump_en),
        .jump_tgt(jump_tgt), .pc(pc), .step(step)
    );

    pc_step_sequencer #(.FIXED_LEN(5)) uut_fix (
        .clk(clk), .rst(rst), .len_sel(len_sel), .jump_en(jump_en),
        .jump_tgt(jump_tgt), .pc(pc_f), .step(step_f)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 pc after reset", pc, 0);
        check("R1 step after reset", step, 0);
        check("R1 fixed pc after reset", pc_f, 0);
        check("R1 fixed step after reset", step_f, 0);
    endtask

    task automatic t_fixed();
        jump_en = 1'b0;
        do_reset();
        for (int i = 0; i < 10; i++) begin
            check("R2 fixed step", step_f, i % 5);
            check("R3 fixed pc hold", pc_f, i / 5);
            tick();
        end
        check("R5 fixed pc after two instr", pc_f, 2);
    endtask

    task automatic t_var(input int n);
        jump_en = 1'b0;
        len_sel = 4'(n);
        do_reset();
        for (int i = 0; i < 2 * n; i++) begin
            check("R6 R4 var step", step, i % n);
            check("R3 var pc hold", pc, i / n);
            tick();
        end
        check("R5 var pc after two instr", pc, 2);
    endtask

    task automatic t_short(input int n);
        jump_en = 1'b0;
        len_sel = 4'(n);
        do_reset();
        for (int i = 0; i < 4; i++) begin
            check("R7 short pc", pc, i);
            check("R7 short step", step, 0);
            tick();
        end
    endtask

    task automatic t_jump();
        len_sel = 4'd2;
        do_reset();
        tick();
        check("R8 at last step", step, 1);
        jump_en = 1'b1;
        jump_tgt = 8'h40;
        tick();
        jump_en = 1'b0;
        check("R8 jump pc", pc, 8'h40);
        check("R8 jump step", step, 0);
        tick();
        tick();
        check("R5 after jump", pc, 8'h41);
    endtask

    task automatic t_jump_ignored();
        len_sel = 4'd4;
        do_reset();
        jump_en = 1'b1;
        jump_tgt = 8'h99;
        tick();
        jump_en = 1'b0;
        check("R9 ignored pc", pc, 0);
        check("R9 ignored step", step, 1);
        tick();
        tick();
        tick();
        check("R9 increment after ignore", pc, 1);
        check("R9 step back to zero", step, 0);
    endtask

    task automatic t_wrap();
        len_sel = 4'd1;
        do_reset();
        jump_en = 1'b1;
        jump_tgt = 8'hFF;
        tick();
        jump_en = 1'b0;
        check("R10 loaded top", pc, 8'hFF);
        tick();
        check("R10 wrap", pc, 0);
    endtask

    task automatic t_shrink();
        len_sel = 4'd8;
        do_reset();
        for (int i = 0; i < 5; i++) tick();
        check("R11 step before shrink", step, 5);
        len_sel = 4'd3;
        tick();
        check("R11 shrink ends instr pc", pc, 1);
        check("R11 shrink ends instr step", step, 0);
        tick();
        tick();
        tick();
        check("R11 new length pc", pc, 2);
    endtask

    task automatic t_mid_reset();
        len_sel = 4'd6;
        do_reset();
        for (int i = 0; i < 9; i++) tick();
        check("R1 before mid reset step", step, 3);
        rst = 1'b1;
        tick();
        check("R1 mid reset pc", pc, 0);
        check("R1 mid reset step", step, 0);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #800000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        #1;
        t_reset();
        t_fixed();
        t_var(3);
        t_var(2);
        t_var(15);
        t_short(0);
        t_short(1);
        t_jump();
        t_jump_ignored();
        t_wrap();
        t_shrink();
        t_mid_reset();
        finish_run();
    end

endmodule